// File: doc/BRIEF.md
# Indexed Real-Time-Clock Register File

This block is the register front end of a CMOS-style real-time clock. Software reaches it through two byte-wide operations sharing one write-data bus: an index load that selects one of fourteen registers, and a data access that reads or writes the selected register. Indices 0x0 to 0x9 hold plain clock and calendar bytes. Indices 0xA to 0xD are status registers: A carries the time-base and rate fields and an update-in-progress flag; B carries the mode and enable bits; C and D read as zero.

Alongside the registers runs a periodic interrupt generator. It counts a fixed number of clock cycles, set by a parameter, and emits a one-cycle pulse each time the count expires. The periodic-enable bit in status B starts and stops it. Illegal operations (an index above 0xD, a write to C or D, an unsupported status A value) leave the state untouched and raise a one-cycle error pulse.

Top module: `rtc_regfile`

## Requirements
- R1: After reset the index is 0x0, the clock bytes read 0x00, status A holds 0x26 (time-base field bits 6:4 = 010, rate field bits 3:0 = 0110), status B holds 0x46 (bit 6 periodic enable, bit 2 binary mode, bit 1 24-hour mode), the interrupt generator is running, and rdata, rvalid, err and irq are low.
- R2: An index load takes wdata when it is 0x0 to 0xD; a larger value keeps the previous index and err is high in the following cycle.
- R3: Indices 0x0 to 0x9 return the byte last written to them.
- R4: A data read presents the value on rdata with rvalid high in the cycle after data_rd; rdata holds otherwise. A data access in the same cycle as an index load uses the index held before that load.
- R5: Every read of status A inverts bit 7 and returns the inverted value; bits 6:0 always read 0x26.
- R6: A status A write of 0x26 stores 0x26 (bit 7 cleared); any other value leaves status A unchanged and raises err in the following cycle.
- R7: A status B write stores the whole byte, which reads back unchanged.
- R8: Status C (0xC) and D (0xD) always read 0x00; writes to them change nothing and raise err in the following cycle.
- R9: While the generator runs, irq is a one-cycle pulse repeating every TICK_CYCLES cycles; after reset or a restart the first pulse is high after TICK_CYCLES-1 rising edges.
- R10: A status B write with bit 6 clear stops the generator (no irq from the next cycle on); with bit 6 set it restarts the full interval only if the generator was stopped and leaves a running count undisturbed.
- R11: When data_rd and data_wr are high together, the read is performed and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_wr | input | 1 | Load the register index from wdata |
| data_wr | input | 1 | Write wdata to the selected register |
| data_rd | input | 1 | Read the selected register |
| wdata | input | 8 | Write data for index and register writes |
| rdata | output | 8 | Read result, held between reads |
| rvalid | output | 1 | One-cycle strobe: rdata carries a new read result |
| err | output | 1 | One-cycle pulse after an illegal operation |
| irq | output | 1 | Periodic interrupt pulse |

## Verification
Two pairs of functions can meet in a single cycle. An index load can coincide with a data read, which must still use the old index; the bench issues both in one cycle and compares rdata against the byte of the previous index. A status B write that clears the enable bit can land in the very cycle the countdown expires; the bench waits for irq high, writes B in that cycle, and requires that pulse to stand alone with no later one, while a cycle-level reference model built from the requirements judges every irq, err and read result, including a random mix of all operations.

// File: rtl/rtc_regs_pkg.sv
package rtc_regs_pkg;

  localparam int BYTE_W        = 8;
  localparam int IDX_W         = 4;
  localparam int NUM_CLK_BYTES = 10;

  localparam logic [IDX_W-1:0] IDX_STAT_A = 4'hA;
  localparam logic [IDX_W-1:0] IDX_STAT_B = 4'hB;
  localparam logic [IDX_W-1:0] IDX_LAST   = 4'hD;

  // status A: bit 7 update flag, 6:4 time base, 3:0 rate
  localparam int                UPD_BIT      = 7;
  localparam logic [BYTE_W-1:0] STAT_A_INIT  = 8'h26;
  // status B: bit 6 periodic enable, bit 2 binary, bit 1 24-hour
  localparam int                PER_EN_BIT   = 6;
  localparam logic [BYTE_W-1:0] STAT_B_INIT  = 8'h46;

  typedef enum logic [1:0] {
    RGN_BANK  = 2'd0,
    RGN_STATA = 2'd1,
    RGN_STATB = 2'd2,
    RGN_ZERO  = 2'd3
  } region_e;

  function automatic region_e decode_region(input logic [IDX_W-1:0] idx);
    if (idx < IDX_W'(NUM_CLK_BYTES)) return RGN_BANK;
    else if (idx == IDX_STAT_A)      return RGN_STATA;
    else if (idx == IDX_STAT_B)      return RGN_STATB;
    else                             return RGN_ZERO;
  endfunction

endpackage

// File: rtl/rtc_index_latch.sv
module rtc_index_latch
  import rtc_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic [IDX_W-1:0]  idx,
  output logic              reject
);

  logic             in_range;
  logic             idx_en;
  logic [IDX_W-1:0] idx_d;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    in_range = (din <= BYTE_W'(IDX_LAST));
    idx_en   = load && in_range;
    reject   = load && !in_range;
    idx_d    = din[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign idx = idx_q;

endmodule

// File: rtl/rtc_data_bank.sv
module rtc_data_bank
  import rtc_regs_pkg::*;
#(
  parameter int NUM_BYTES = NUM_CLK_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [IDX_W-1:0]  sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);

  logic [BYTE_W-1:0] bytes_q [NUM_BYTES];

  for (genvar gi = 0; gi < NUM_BYTES; gi++) begin : g_byte
    logic hit_en;

    always_comb begin
      hit_en = wr && (sel == IDX_W'(gi));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bytes_q[gi] <= '0;
      end else if (hit_en) begin
        bytes_q[gi] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (sel == IDX_W'(i)) rdata = bytes_q[i];
    end
  end

endmodule

// File: rtl/rtc_status_regs.sv
module rtc_status_regs
  import rtc_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_rd,
  input  logic              a_wr,
  input  logic              b_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] a_read_val,
  output logic [BYTE_W-1:0] b_val,
  output logic              a_bad
);

  localparam logic [BYTE_W-1:0] UPD_MASK = BYTE_W'(1) << UPD_BIT;

  logic [BYTE_W-1:0] a_q, a_d;
  logic              a_en;
  logic [BYTE_W-1:0] b_q;
  logic              a_ok;

  always_comb begin
    a_read_val = a_q ^ UPD_MASK;
    a_ok       = (wdata == STAT_A_INIT);
    a_bad      = a_wr && !a_ok;
    a_en       = a_rd || (a_wr && a_ok);
    if (a_rd) a_d = a_read_val;
    else      a_d = STAT_A_INIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= STAT_A_INIT;
    end else if (a_en) begin
      a_q <= a_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q <= STAT_B_INIT;
    end else if (b_wr) begin
      b_q <= wdata;
    end
  end

  assign b_val = b_q;

endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int TICK_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_en,
  output logic tick
);

  localparam int               CNT_W  = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TICK_CYCLES - 1);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             expire;
  logic [CNT_W-1:0] cnt_step;

  always_comb begin
    expire   = run_q && (cnt_q == '0);
    cnt_step = (cnt_q == '0) ? RELOAD : cnt_q - CNT_W'(1);
    run_d    = run_q;
    cnt_d    = cnt_q;
    if (ctl_wr && !ctl_en) begin
      run_d = 1'b0;
    end else if (ctl_wr && ctl_en && !run_q) begin
      run_d = 1'b1;
      cnt_d = RELOAD;
    end else if (run_q) begin
      cnt_d = cnt_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b1;
      cnt_q <= RELOAD;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign tick = expire;

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_regs_pkg::*;
#(
  parameter int TICK_CYCLES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       data_wr,
  input  logic       data_rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rvalid,
  output logic       err,
  output logic       irq
);

  logic [IDX_W-1:0]  cur_idx;
  logic              idx_reject;
  region_e           region;
  logic              wr_go;
  logic              bank_wr, a_rd, a_wr, b_wr, zero_wr;
  logic [BYTE_W-1:0] bank_rdata, a_read_val, b_val;
  logic              a_bad;
  logic [BYTE_W-1:0] rd_mux;
  logic              err_d;
  logic [BYTE_W-1:0] rdata_q;
  logic              rvalid_q, err_q;

  rtc_index_latch u_idx (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (idx_wr),
    .din    (wdata),
    .idx    (cur_idx),
    .reject (idx_reject)
  );

  always_comb begin
    region  = decode_region(cur_idx);
    wr_go   = data_wr && !data_rd;
    bank_wr = wr_go   && (region == RGN_BANK);
    a_rd    = data_rd && (region == RGN_STATA);
    a_wr    = wr_go   && (region == RGN_STATA);
    b_wr    = wr_go   && (region == RGN_STATB);
    zero_wr = wr_go   && (region == RGN_ZERO);
  end

  rtc_data_bank #(.NUM_BYTES(NUM_CLK_BYTES)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bank_wr),
    .sel   (cur_idx),
    .wdata (wdata),
    .rdata (bank_rdata)
  );

  rtc_status_regs u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_rd       (a_rd),
    .a_wr       (a_wr),
    .b_wr       (b_wr),
    .wdata      (wdata),
    .a_read_val (a_read_val),
    .b_val      (b_val),
    .a_bad      (a_bad)
  );

  rtc_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl_wr (b_wr),
    .ctl_en (wdata[PER_EN_BIT]),
    .tick   (irq)
  );

  always_comb begin
    unique case (region)
      RGN_BANK:  rd_mux = bank_rdata;
      RGN_STATA: rd_mux = a_read_val;
      RGN_STATB: rd_mux = b_val;
      default:   rd_mux = '0;
    endcase
    err_d = idx_reject || a_bad || zero_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (data_rd) begin
      rdata_q <= rd_mux;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= data_rd;
      err_q    <= err_d;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;
  assign err    = err_q;

endmodule

// File: rtl/rtc_regfile_checker.sv
module rtc_regfile_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       idx_wr,
  input logic       data_wr,
  input logic       data_rd,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       rvalid,
  input logic       err,
  input logic       irq,
  input logic [3:0] cur_idx
);

  assert_index_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && wdata > 8'h0D) |=> (err && $stable(cur_idx)));

  assert_index_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && wdata <= 8'h0D) |=> (cur_idx == $past(wdata[3:0])));

  assert_read_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd |=> rvalid);

  assert_no_idle_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rd |=> !rvalid);

  assert_stat_a_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && cur_idx == 4'hA) |=> (rdata[6:0] == 7'h26));

  assert_stat_cd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && cur_idx >= 4'hC) |=> (rdata == 8'h00));

  assert_stat_cd_write_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !data_rd && cur_idx >= 4'hC) |=> err);

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_stop_silences_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !data_rd && cur_idx == 4'hB && !wdata[6]) |=> !irq);

endmodule

bind rtc_regfile rtc_regfile_checker u_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .idx_wr  (idx_wr),
  .data_wr (data_wr),
  .data_rd (data_rd),
  .wdata   (wdata),
  .rdata   (rdata),
  .rvalid  (rvalid),
  .err     (err),
  .irq     (irq),
  .cur_idx (cur_idx)
);

// File: tb/rtc_regfile_bench.sv
`timescale 1ns/1ps
module rtc_regfile_bench;

  localparam int N = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       iw = 1'b0, dw = 1'b0, dr = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rdata;
  logic       rvalid, err, irq;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_regfile #(.TICK_CYCLES(N)) u_rtc_regfile (
    .clk(clk), .rst_n(rst_n), .idx_wr(iw), .data_wr(dw), .data_rd(dr),
    .wdata(wd), .rdata(rdata), .rvalid(rvalid), .err(err), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, built from the requirements
  logic [7:0] m_bank [10];
  logic [7:0] m_a, m_b, exp_rd;
  logic [3:0] m_idx;
  bit         m_run, exp_rv, exp_err;
  int         m_cnt;
  string      exp_tag, err_tag;

  function automatic int next_cnt(input int c);
    return (c == 0) ? N - 1 : c - 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 10; i++) m_bank[i] <= 8'h00;
      m_a <= 8'h26; m_b <= 8'h46; m_idx <= 4'h0;
      m_run <= 1'b1; m_cnt <= N - 1;
      exp_rv <= 1'b0; exp_err <= 1'b0; exp_rd <= 8'h00;
      exp_tag <= "R3"; err_tag <= "R2";
    end else begin
      exp_rv  <= dr;
      exp_err <= 1'b0;
      if (dr) begin
        if (m_idx < 4'hA) begin exp_rd <= m_bank[m_idx]; exp_tag <= dw ? "R11" : "R3"; end
        else if (m_idx == 4'hA) begin exp_rd <= m_a ^ 8'h80; m_a <= m_a ^ 8'h80; exp_tag <= "R5"; end
        else if (m_idx == 4'hB) begin exp_rd <= m_b; exp_tag <= "R7"; end
        else begin exp_rd <= 8'h00; exp_tag <= "R8"; end
      end else if (dw) begin
        if (m_idx < 4'hA) m_bank[m_idx] <= wd;
        else if (m_idx == 4'hA) begin
          if (wd == 8'h26) m_a <= 8'h26;
          else begin exp_err <= 1'b1; err_tag <= "R6"; end
        end else if (m_idx == 4'hB) m_b <= wd;
        else begin exp_err <= 1'b1; err_tag <= "R8"; end
      end
      if (iw) begin
        if (wd <= 8'h0D) m_idx <= wd[3:0];
        else begin exp_err <= 1'b1; err_tag <= "R2"; end
      end
      if (dw && !dr && m_idx == 4'hB) begin
        if (!wd[6]) m_run <= 1'b0;
        else if (!m_run) begin m_run <= 1'b1; m_cnt <= N - 1; end
        else m_cnt <= next_cnt(m_cnt);
      end else if (m_run) begin
        m_cnt <= next_cnt(m_cnt);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rvalid || exp_rv) check(rvalid == exp_rv, "R4", rvalid, exp_rv);
      if (rvalid && exp_rv) check(rdata == exp_rd, exp_tag, rdata, exp_rd);
      if (err || exp_err) check(err == exp_err, err_tag, err, exp_err);
      if (irq || (m_run && m_cnt == 0))
        check(irq == (m_run && m_cnt == 0), "R9/R10", irq, m_run && m_cnt == 0);
    end
  end

  // callers stand at a negedge; returns at the negedge where results show
  task automatic op(input bit i_w, input bit d_w, input bit d_r, input logic [7:0] v);
    iw = i_w; dw = d_w; dr = d_r; wd = v;
    @(negedge clk);
    iw = 1'b0; dw = 1'b0; dr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int quiet;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check(rvalid == 0 && err == 0 && irq == 0 && rdata == 8'h00, "R1", {rvalid, err, irq, rdata}, 0);
    op(1, 0, 1, 8'h0B);               // read index 0 while loading B (R4)
    check(rdata == 8'h00, "R1", rdata, 8'h00);
    op(0, 0, 1, 8'h00);
    check(rdata == 8'h46, "R1", rdata, 8'h46);
    op(1, 0, 0, 8'h0A);
    op(0, 0, 1, 8'h00);
    check(rdata == 8'hA6, "R5", rdata, 8'hA6);
    op(0, 0, 1, 8'h00);
    check(rdata == 8'h26, "R5", rdata, 8'h26);
    op(0, 0, 1, 8'h00);               // A now has bit 7 set
    op(0, 1, 0, 8'h55);
    check(err == 1'b1, "R6", err, 1);
    op(0, 0, 1, 8'h00);
    check(rdata == 8'h26, "R6", rdata, 8'h26);
    op(0, 0, 1, 8'h00);
    op(0, 1, 0, 8'h26);
    op(0, 0, 1, 8'h00);
    check(rdata == 8'hA6, "R6", rdata, 8'hA6);
    op(1, 0, 0, 8'h0E);
    check(err == 1'b1, "R2", err, 1);
    op(1, 0, 0, 8'hFF);
    op(0, 0, 1, 8'h00);
    check(rdata[6:0] == 7'h26, "R2", rdata, 8'h26);
    op(1, 0, 0, 8'h03);
    op(0, 1, 0, 8'h5A);
    op(1, 0, 0, 8'h09);
    op(0, 1, 0, 8'hC3);
    op(1, 0, 1, 8'h03);               // old index 9 read during load
    check(rdata == 8'hC3, "R4", rdata, 8'hC3);
    op(0, 0, 1, 8'h00);
    check(rdata == 8'h5A, "R3", rdata, 8'h5A);
    op(0, 1, 1, 8'h77);               // read wins, write dropped
    check(rdata == 8'h5A, "R11", rdata, 8'h5A);
    op(0, 0, 1, 8'h00);
    check(rdata == 8'h5A, "R11", rdata, 8'h5A);
    for (int k = 12; k <= 13; k++) begin
      op(1, 0, 0, 8'(k));
      op(0, 1, 0, 8'hFF);
      check(err == 1'b1, "R8", err, 1);
      op(0, 0, 1, 8'h00);
      check(rdata == 8'h00, "R8", rdata, 8'h00);
    end
    idle(3 * N);
    // stop the generator in the very cycle it expires
    op(1, 0, 0, 8'h0B);
    while (!irq) @(negedge clk);
    op(0, 1, 0, 8'h06);
    quiet = 0;
    for (int c = 0; c < 3 * N; c++) begin
      if (irq) quiet++;
      @(negedge clk);
    end
    check(quiet == 0, "R10", quiet, 0);
    op(0, 0, 1, 8'h00);
    check(rdata == 8'h06, "R7", rdata, 8'h06);
    op(0, 1, 0, 8'h46);               // restart full interval
    idle(N / 2);
    op(0, 1, 0, 8'h4E);               // running: count undisturbed
    idle(3 * N);
    // random mix
    for (int it = 0; it < 1500; it++) begin
      int sel;
      logic [7:0] v;
      sel = int'($urandom % 8);
      v = 8'($urandom);
      if (sel < 2) op(1, 0, 0, 8'($urandom % 16));
      else if (sel < 5) op(0, 0, 1, 8'h00);
      else if (sel < 7) op(0, 1, 0, ($urandom % 4 == 0) ? 8'h26 : v);
      else op(0, 1, 1, v);
      idle(int'($urandom % 3));
    end
    idle(4);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule